// File: doc/BRIEF.md
# Framebuffer Pixel Component Extractor

This block turns raw framebuffer words into one 8-bit red, green and blue triple per pixel. Three static control words set the pixel layout:

- A format word gives the number of bytes per pixel.
- Three select words, one per colour, each give a lowest bit index, a bit count and a substitute default value.

On the input side, a valid/ready stream delivers one pixel word per beat. Byte lane 0 holds the first byte of the pixel. Two flags come with each beat: a blank flag marks pixels outside the active area, and an underrun flag marks beats where the fetch side had no data.

Lanes beyond the programmed byte count are cleared before extraction. Each colour field is cut out of the assembled word at its own offset and width, then widened to 8 bits by repeating its own upper bits into the low positions. The default value of a colour replaces the extracted bits in three cases: when its count is zero, when the pixel is blanked, and when the input underruns. Setting the red default to 0xFF therefore makes every underrun show as solid red. The outputs are registered, so a result appears one cycle after the beat that produced it.

Top module: `fb_pixel_unpack`

## Requirements
- R1: While rst_ni is low, valid_o is 0, red_o, grn_o and blu_o are 0 and ready_o is 0; the reset acts asynchronously.
- R2: Results appear one clock after the inputs that produce them; valid_o is 1 in the cycle after any of word_valid_i, blank_i or underrun_i was 1, and 0 otherwise.
- R3: fmt_i bits [4:3] hold bytes-per-pixel minus one (0 = one byte, 3 = four bytes); lane 0 (word_i[7:0]) is the first pixel byte; lanes at or above the byte count read as zero.
- R4: Each select word holds the lowest bit index in bits [4:0], the bit count in bits [11:8] and the default value in bits [23:16].
- R5: A component takes count bits of the assembled word starting at the lowest bit index; bits above bit 31 read as zero, and a count above 8 is treated as 8.
- R6: A field of n bits (n < 8) is placed in the top n bits of the output and its own upper bits repeat into the lower bits: 5-bit 0x10 gives 0x84, 6-bit 0x20 gives 0x82, 3-bit 0b101 gives 0xB6, 2-bit 0b10 gives 0xAA and 5-bit 0x1F gives 0xFF.
- R7: A colour whose count field is zero outputs its default value while the other colours extract normally.
- R8: With blank_i at 1, all three outputs show their defaults whether or not word_valid_i is 1, and ready_o is 0, so the word is not consumed.
- R9: With underrun_i at 1, all three outputs show their defaults and the data on word_i has no effect.
- R10: When word_valid_i, blank_i and underrun_i are all 0, the colour outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 32 | Format word; bits [4:3] = bytes per pixel minus one |
| red_sel_i | input | 32 | Red select: offset [4:0], count [11:8], default [23:16] |
| grn_sel_i | input | 32 | Green select, same layout |
| blu_sel_i | input | 32 | Blue select, same layout |
| word_i | input | 32 | Raw pixel bytes, lane 0 in bits [7:0] |
| word_valid_i | input | 1 | word_i holds a pixel |
| ready_o | output | 1 | Word accepted this cycle |
| underrun_i | input | 1 | Fetch side had no data for this pixel |
| blank_i | input | 1 | Pixel lies outside the active area |
| red_o | output | 8 | Red component |
| grn_o | output | 8 | Green component |
| blu_o | output | 8 | Blue component |
| valid_o | output | 1 | Output triple is valid |

## Verification
The hardest conditions to reach are the edge cases of field placement. These include a field that runs past bit 31, a count field larger than 8, and a wide pixel word whose upper lanes carry stale bytes that the byte count must discard. The vector table reaches each of these by combining a narrow format word with a word_i full of non-zero upper bytes, and by placing an offset close to the top of the word. Underrun is driven together with a word whose value would give a different result, so that any leak of the word onto the outputs shows up.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
  localparam int SEL_OFF_LSB = 0;
  localparam int SEL_OFF_W   = 5;
  localparam int SEL_CNT_LSB = 8;
  localparam int SEL_CNT_W   = 4;
  localparam int SEL_DEF_LSB = 16;
  localparam int SEL_DEF_W   = 8;
  localparam int FMT_BPP_LSB = 3;
  localparam int NUM_COMP    = 3;

  typedef struct packed {
    logic [SEL_DEF_W-1:0] dflt;
    logic [SEL_CNT_W-1:0] cnt;
    logic [SEL_OFF_W-1:0] off;
  } comp_cfg_t;

  function automatic comp_cfg_t decode_sel(input logic [31:0] sel);
    comp_cfg_t c;
    c.off  = sel[SEL_OFF_LSB +: SEL_OFF_W];
    c.cnt  = sel[SEL_CNT_LSB +: SEL_CNT_W];
    c.dflt = sel[SEL_DEF_LSB +: SEL_DEF_W];
    return c;
  endfunction
endpackage

// File: rtl/fbx_lane_pack.sv
module fbx_lane_pack #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W,
  localparam int BPP_W  = $clog2(LANES)
) (
  input  logic [WORD_W-1:0] raw_i,
  input  logic [BPP_W-1:0]  bpp_m1_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // lanes above the programmed byte count are cleared
    assign word_o[l*LANE_W +: LANE_W] =
      (BPP_W'(l) <= bpp_m1_i) ? raw_i[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/fbx_comp_extract.sv
module fbx_comp_extract #(
  parameter int WORD_W = 32,
  parameter int OUT_W  = 8,
  parameter int OFF_W  = 5,
  parameter int CNT_W  = 4
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [OUT_W-1:0]  dflt_i,
  input  logic              force_dflt_i,
  output logic [OUT_W-1:0]  comp_o
);
  logic [CNT_W-1:0]  n;
  logic [WORD_W-1:0] shifted;
  logic [OUT_W-1:0]  field;
  logic [OUT_W-1:0]  top_al;
  logic [OUT_W-1:0]  scaled;

  always_comb begin
    n       = (cnt_i > CNT_W'(OUT_W)) ? CNT_W'(OUT_W) : cnt_i;
    shifted = word_i >> off_i;
    field   = '0;
    for (int b = 0; b < OUT_W; b++) begin
      if (b < int'(n)) field[b] = shifted[b];
    end
    top_al = field << (OUT_W - int'(n));
    // repeat the field downward until all output bits are filled
    scaled = '0;
    for (int j = 0; j < OUT_W; j++) begin
      scaled = scaled | (top_al >> (j * int'(n)));
    end
    comp_o = (force_dflt_i || cnt_i == '0) ? dflt_i : scaled;
  end
endmodule

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack
  import fbx_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int OUT_W  = 8,
  localparam int WORD_W = LANES * LANE_W,
  localparam int BPP_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       fmt_i,
  input  logic [31:0]       red_sel_i,
  input  logic [31:0]       grn_sel_i,
  input  logic [31:0]       blu_sel_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              ready_o,
  input  logic              underrun_i,
  input  logic              blank_i,
  output logic [OUT_W-1:0]  red_o,
  output logic [OUT_W-1:0]  grn_o,
  output logic [OUT_W-1:0]  blu_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] packed_word;
  logic [BPP_W-1:0]  bpp_m1;
  logic              force_dflt;
  logic              take;
  comp_cfg_t         cfg   [NUM_COMP];
  logic [OUT_W-1:0]  comp  [NUM_COMP];
  logic [OUT_W-1:0]  rgb_q [NUM_COMP];
  logic              valid_q;

  assign bpp_m1     = fmt_i[FMT_BPP_LSB +: BPP_W];
  assign force_dflt = blank_i | underrun_i;
  assign take       = word_valid_i | force_dflt;
  assign ready_o    = rst_ni & ~blank_i;

  assign cfg[0] = decode_sel(red_sel_i);
  assign cfg[1] = decode_sel(grn_sel_i);
  assign cfg[2] = decode_sel(blu_sel_i);

  fbx_lane_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
    .raw_i    (word_i),
    .bpp_m1_i (bpp_m1),
    .word_o   (packed_word)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    fbx_comp_extract #(
      .WORD_W(WORD_W), .OUT_W(OUT_W), .OFF_W(SEL_OFF_W), .CNT_W(SEL_CNT_W)
    ) u_ext (
      .word_i       (packed_word),
      .off_i        (cfg[c].off),
      .cnt_i        (cfg[c].cnt),
      .dflt_i       (OUT_W'(cfg[c].dflt)),
      .force_dflt_i (force_dflt),
      .comp_o       (comp[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rgb_q[c] <= '0;
      else if (take) rgb_q[c] <= comp[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= take;
  end

  assign red_o   = rgb_q[0];
  assign grn_o   = rgb_q[1];
  assign blu_o   = rgb_q[2];
  assign valid_o = valid_q;
endmodule

// File: rtl/fbx_chk.sv
module fbx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] red_sel_i,
  input logic [31:0] grn_sel_i,
  input logic [31:0] blu_sel_i,
  input logic        word_valid_i,
  input logic        underrun_i,
  input logic        blank_i,
  input logic [7:0]  red_o,
  input logic [7:0]  grn_o,
  input logic [7:0]  blu_o,
  input logic        valid_o
);
  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i || blank_i || underrun_i) |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i || blank_i || underrun_i) |=> !valid_o);
  // R8
  blank_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (red_o == $past(red_sel_i[23:16]) && grn_o == $past(grn_sel_i[23:16])
                 && blu_o == $past(blu_sel_i[23:16])));
  // R9
  underrun_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_i |=> (red_o == $past(red_sel_i[23:16]) && grn_o == $past(grn_sel_i[23:16])
                    && blu_o == $past(blu_sel_i[23:16])));
  // R7
  cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && grn_sel_i[11:8] == 4'd0) |=> grn_o == $past(grn_sel_i[23:16]));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_i || blank_i || underrun_i) |=> $stable({red_o, grn_o, blu_o}));
endmodule

bind fb_pixel_unpack fbx_chk u_chk (.*);

// File: tb/sim_fb_pixel_unpack.sv
`timescale 1ns/1ps
module sim_fb_pixel_unpack;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fmt_i = '0, red_sel_i = '0, grn_sel_i = '0, blu_sel_i = '0, word_i = '0;
  logic        word_valid_i = 1'b0, underrun_i = 1'b0, blank_i = 1'b0;
  logic        ready_o, valid_o;
  logic [7:0]  red_o, grn_o, blu_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fb_pixel_unpack u0 (.*);

  localparam int NV = 9;
  localparam logic [31:0] T_FMT [NV] = '{32'h08, 32'h08, 32'h08, 32'h08, 32'h18,
                                        32'h00, 32'h18, 32'h18, 32'h10};
  localparam logic [31:0] T_RS  [NV] = '{32'h50B, 32'h50B, 32'h50B, 32'h50B, 32'h810,
                                        32'h305, 32'h810, 32'hF10, 32'h810};
  localparam logic [31:0] T_GS  [NV] = '{32'h605, 32'h605, 32'h605, 32'h605, 32'h808,
                                        32'h302, 32'h005A0000, 32'h808, 32'h818};
  localparam logic [31:0] T_BS  [NV] = '{32'h500, 32'h500, 32'h500, 32'h500, 32'h800,
                                        32'h200, 32'h800, 32'h81C, 32'h800};
  localparam logic [31:0] T_WD  [NV] = '{32'h0000FFFF, 32'h0000F800, 32'h00008410,
                                        32'hABCD8410, 32'h11223344, 32'hFFFFFFB6,
                                        32'h11223344, 32'h11223344, 32'h11223344};
  localparam logic [23:0] T_EXP [NV] = '{24'hFFFFFF, 24'hFF0000, 24'h848284,
                                        24'h848284, 24'h223344, 24'hB6B6AA,
                                        24'h225A44, 24'h223301, 24'h220044};
  localparam string T_REQ [NV] = '{"R6", "R5", "R6", "R3", "R4", "R6", "R7", "R5", "R3"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {31'd0, valid_o}, 32'd0);
    chk("R1", {8'd0, red_o, grn_o, blu_o}, 32'd0);
    chk("R1", {31'd0, ready_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      fmt_i = T_FMT[i]; red_sel_i = T_RS[i]; grn_sel_i = T_GS[i];
      blu_sel_i = T_BS[i]; word_i = T_WD[i]; word_valid_i = 1'b1;
      if (i == 0) begin
        #1;
        // R2 nothing visible before the capturing edge
        chk("R2", {31'd0, valid_o}, 32'd0);
      end
      @(negedge clk_i);
      chk(T_REQ[i], {8'd0, red_o, grn_o, blu_o}, {8'd0, T_EXP[i]});
      chk("R2", {31'd0, valid_o}, 32'd1);
    end

    // R10 hold with no input
    word_valid_i = 1'b0; word_i = 32'hDEADBEEF;
    @(negedge clk_i);
    chk("R10", {8'd0, red_o, grn_o, blu_o}, {8'd0, T_EXP[NV-1]});
    chk("R2", {31'd0, valid_o}, 32'd0);

    // R8 blank with a word present
    fmt_i = 32'h18; red_sel_i = 32'h00FF0810; grn_sel_i = 32'h00120808;
    blu_sel_i = 32'h00340800; word_i = 32'h11223344; word_valid_i = 1'b1; blank_i = 1'b1;
    #1 chk("R8", {31'd0, ready_o}, 32'd0);
    @(negedge clk_i);
    chk("R8", {8'd0, red_o, grn_o, blu_o}, 32'h00FF1234);
    // R8 blank alone still yields valid defaults
    word_valid_i = 1'b0; red_sel_i = 32'h00AB0810;
    @(negedge clk_i);
    chk("R8", {8'd0, red_o, grn_o, blu_o}, 32'h00AB1234);
    chk("R8", {31'd0, valid_o}, 32'd1);

    // R9 underrun ignores the word
    blank_i = 1'b0; underrun_i = 1'b1; word_valid_i = 1'b1;
    red_sel_i = 32'h00FF0810; word_i = 32'h55667788;
    #1 chk("R9", {31'd0, ready_o}, 32'd1);
    @(negedge clk_i);
    chk("R9", {8'd0, red_o, grn_o, blu_o}, 32'h00FF1234);
    chk("R9", {31'd0, valid_o}, 32'd1);

    // normal pixel after underrun
    underrun_i = 1'b0; word_i = 32'h11223344;
    @(negedge clk_i);
    chk("R5", {8'd0, red_o, grn_o, blu_o}, 32'h00223344);

    // R1 asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R1", {31'd0, valid_o}, 32'd0);
    chk("R1", {8'd0, red_o, grn_o, blu_o}, 32'd0);
    @(negedge clk_i);
    finish_run();
  end
endmodule